// File: doc/BRIEF.md
# Software-Loaded Unified Translation Buffer

This block is a fully associative buffer of address translations whose contents are owned by software. Software first stages a translation in two holding registers: a high word carrying the virtual page number and address-space identifier, and a low word carrying the physical page number, the valid and dirty flags and the page attributes. A single load pulse then copies both staging registers into the entry that the replacement counter currently points at. The counter then advances and wraps at a boundary that software programs.

A privileged, word-wide memory-mapped port gives direct read and write access to every entry through two views. The tag view carries the virtual page number, the address-space identifier and the valid and dirty flags. The payload view carries the physical page number, the attributes and the same valid and dirty flags. Each entry holds only one valid bit and one dirty bit, so both views see the same two bits. A combinational lookup port takes a virtual page number and the current address-space identifier. It returns hit, multi-hit, the physical page number and the attribute byte.

Top module: `utlb_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every entry to all-zero, so every valid bit is 0 and every read through either view returns 0. It also sets the counter `ctl_urc` and the boundary `ctl_urb` to 0.
- R2: A `load_cmd` pulse writes the staged high word (VPN at bits [31:10], ASID at [7:0]) and the staged low word (payload-view layout of R8) into the entry indexed by `ctl_urc` at that edge. Bits [9:8] of the high word are discarded. A staging write in the same cycle as the load does not reach the entry.
- R3: After each load without a control write, the counter becomes `ctl_urc+1` modulo the entry count. When `ctl_urb` is nonzero and that sum equals `ctl_urb`, the counter becomes 0 instead. A counter above the boundary keeps counting up to the top entry and then wraps to 0. Without a load or control write, counter and boundary hold.
- R4: A control write (`ctl_we`) loads `ctl_urc` and `ctl_urb` at the next edge. It takes priority over the advance caused by a load in the same cycle. That load still fills the entry selected by the old counter.
- R5: A lookup hits when an entry is valid, its VPN equals `lk_vpn`, and either its shared flag is set or its ASID equals `lk_asid`. `lk_ppn` and `lk_attr` come from the lowest-indexed hitting entry. `lk_attr` is {SZ[1:0], PR[1:0], C, D, WT, SH} from bit 7 down, and both outputs are 0 on a miss.
- R6: `lk_multi` is 1 exactly when two or more entries hit, and it implies `lk_hit`.
- R7: Port address bits [13:8] give the entry index and bit 24 selects the view, 0 for the tag view. A tag-view word carries VPN at [31:10], D at [9], V at [8] and ASID at [7:0].
- R8: A payload-view word carries PPN at [28:10], V at [9], D at [8], SZ at [7:6], PR at [5:4], C at [3], WT at [2] and SH at [1]. Bits [31:29] and [0] are ignored on write and read as 0.
- R9: A write to V or D through either view is visible through the other view and in lookups.
- R10: An access is accepted only with `mm_size` = 2'b10 (word), `mm_priv` = 1, `mm_ifetch` = 0 and `mm_addr[1:0]` = 0. A request that fails any test raises `mm_err` in the next cycle, writes nothing and gives no `mm_rvalid`.
- R11: An accepted read raises `mm_rvalid` one cycle later, with `mm_rdata` holding the selected word as it stood at the request edge, and `mm_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pth_we | input | 1 | Write enable of the high staging register |
| pth_wdata | input | 32 | High staging word: VPN and ASID |
| ptl_we | input | 1 | Write enable of the low staging register |
| ptl_wdata | input | 32 | Low staging word, payload-view layout |
| ctl_we | input | 1 | Control write of counter and boundary |
| ctl_urc_wr | input | IDX_W (6) | New replacement counter value |
| ctl_urb_wr | input | IDX_W (6) | New wrap boundary value |
| load_cmd | input | 1 | Copy staging registers into entry `ctl_urc` |
| ctl_urc | output | IDX_W (6) | Replacement counter |
| ctl_urb | output | IDX_W (6) | Wrap boundary |
| mm_req | input | 1 | Memory-mapped access request |
| mm_we | input | 1 | 1 for write, 0 for read |
| mm_size | input | 2 | Access size, 2'b10 = 32-bit word |
| mm_priv | input | 1 | Requester is privileged |
| mm_ifetch | input | 1 | Access is an instruction fetch |
| mm_addr | input | 32 | Access address |
| mm_wdata | input | 32 | Write word |
| mm_rvalid | output | 1 | Read data valid |
| mm_rdata | output | 32 | Read word |
| mm_err | output | 1 | Access rejected |
| lk_vpn | input | VPN_W (22) | Lookup virtual page number |
| lk_asid | input | ASID_W (8) | Current address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_multi | output | 1 | More than one entry hit |
| lk_ppn | output | PPN_W (19) | Physical page number of the hit |
| lk_attr | output | 8 | Attributes of the hit |

## Verification
The properties assume that `mm_size`, `mm_priv`, `mm_ifetch` and the low address bits are meaningful whenever `mm_req` is high. They also assume that a control write and a load may share a cycle, while staging and port traffic never overlap with a load in a way that matters to the counter. The stimulus issues at most one port request per cycle as a one-cycle pulse and holds every qualifier steady across the edge. It also drives loads, control writes and port accesses in separate cycles, except for one directed case that drives a control write and a load together. The random traffic draws page numbers from a small pool and identifiers from a small range, so hits, misses, shared-flag hits and multiple hits all occur often. Any field value of the staged words can appear, reserved bits included.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

   // Field widths of one translation
   localparam int VPN_W  = 22;
   localparam int PPN_W  = 19;
   localparam int ASID_W = 8;

   // Tag-view word positions (also the high staging word)
   localparam int A_VPN_LSB = 10;
   localparam int A_D_BIT   = 9;
   localparam int A_V_BIT   = 8;

   // Payload-view word positions (also the low staging word)
   localparam int D_PPN_LSB = 10;
   localparam int D_V_BIT   = 9;
   localparam int D_D_BIT   = 8;
   localparam int D_SZ_LSB  = 6;
   localparam int D_PR_LSB  = 4;
   localparam int D_C_BIT   = 3;
   localparam int D_WT_BIT  = 2;
   localparam int D_SH_BIT  = 1;

   localparam logic [1:0] SZ_WORD = 2'b10;

   typedef struct packed {
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic [PPN_W-1:0]  ppn;
      logic [1:0]        sz;
      logic [1:0]        pr;
      logic              c;
      logic              d;
      logic              wt;
      logic              sh;
      logic              v;
   } tlb_ent_t;

   typedef struct packed {
      logic [1:0] sz;
      logic [1:0] pr;
      logic       c;
      logic       d;
      logic       wt;
      logic       sh;
   } tlb_attr_t;

   function automatic logic [31:0] pack_tag(tlb_ent_t e);
      logic [31:0] w;
      w = '0;
      w[A_VPN_LSB +: VPN_W] = e.vpn;
      w[A_D_BIT]            = e.d;
      w[A_V_BIT]            = e.v;
      w[ASID_W-1:0]         = e.asid;
      return w;
   endfunction

   function automatic logic [31:0] pack_pay(tlb_ent_t e);
      logic [31:0] w;
      w = '0;
      w[D_PPN_LSB +: PPN_W] = e.ppn;
      w[D_V_BIT]            = e.v;
      w[D_D_BIT]            = e.d;
      w[D_SZ_LSB +: 2]      = e.sz;
      w[D_PR_LSB +: 2]      = e.pr;
      w[D_C_BIT]            = e.c;
      w[D_WT_BIT]           = e.wt;
      w[D_SH_BIT]           = e.sh;
      return w;
   endfunction

   function automatic tlb_ent_t merge_tag(tlb_ent_t e, logic [31:0] w);
      tlb_ent_t r;
      r      = e;
      r.vpn  = w[A_VPN_LSB +: VPN_W];
      r.d    = w[A_D_BIT];
      r.v    = w[A_V_BIT];
      r.asid = w[ASID_W-1:0];
      return r;
   endfunction

   function automatic tlb_ent_t merge_pay(tlb_ent_t e, logic [31:0] w);
      tlb_ent_t r;
      r     = e;
      r.ppn = w[D_PPN_LSB +: PPN_W];
      r.v   = w[D_V_BIT];
      r.d   = w[D_D_BIT];
      r.sz  = w[D_SZ_LSB +: 2];
      r.pr  = w[D_PR_LSB +: 2];
      r.c   = w[D_C_BIT];
      r.wt  = w[D_WT_BIT];
      r.sh  = w[D_SH_BIT];
      return r;
   endfunction

   function automatic tlb_attr_t attr_of(tlb_ent_t e);
      tlb_attr_t a;
      a.sz = e.sz;
      a.pr = e.pr;
      a.c  = e.c;
      a.d  = e.d;
      a.wt = e.wt;
      a.sh = e.sh;
      return a;
   endfunction

endpackage

// File: rtl/utlb_repl.sv
module utlb_repl #(
   parameter  int ENTRIES = 64,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ctl_we,
   input  logic [IDX_W-1:0] urc_wr,
   input  logic [IDX_W-1:0] urb_wr,
   input  logic             load,
   output logic [IDX_W-1:0] urc,
   output logic [IDX_W-1:0] urb
);

   logic [IDX_W-1:0] inc;
   logic [IDX_W-1:0] nxt;

   // Natural roll-over when the entry count fills the index range,
   // explicit compare against the top entry otherwise.
   if ((1 << IDX_W) == ENTRIES) begin : g_pow2
      assign inc = urc + 1'b1;
   end else begin : g_npow2
      assign inc = (urc >= IDX_W'(ENTRIES - 1)) ? '0 : IDX_W'(urc + 1'b1);
   end

   assign nxt = ((urb != '0) && (inc == urb)) ? '0 : inc;

   always_ff @(posedge clk) begin
      if (rst) begin
         urc <= '0;
         urb <= '0;
      end else if (ctl_we) begin
         urc <= urc_wr;
         urb <= urb_wr;
      end else if (load) begin
         urc <= nxt;
      end
   end

endmodule

// File: rtl/utlb_store.sv
module utlb_store
   import utlb_pkg::*;
#(
   parameter  int ENTRIES = 64,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  tlb_ent_t          ld_ent,
   input  logic              mw_en,
   input  logic              mw_pay,
   input  logic [IDX_W-1:0]  mw_idx,
   input  logic [31:0]       mw_word,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [31:0]       rd_tag,
   output logic [31:0]       rd_pay,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic              lk_multi,
   output logic [PPN_W-1:0]  lk_ppn,
   output tlb_attr_t         lk_attr
);

   tlb_ent_t           view [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic               unused_mw;

   assign unused_mw = ^mw_word;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      tlb_ent_t e;

      // Load has priority over a port write to the same entry
      always_ff @(posedge clk) begin
         if (rst) begin
            e <= '0;
         end else if (ld_en && (ld_idx == IDX_W'(g))) begin
            e <= ld_ent;
         end else if (mw_en && (mw_idx == IDX_W'(g))) begin
            e <= mw_pay ? merge_pay(e, mw_word) : merge_tag(e, mw_word);
         end
      end

      assign view[g]  = e;
      assign match[g] = e.v && (e.vpn == lk_vpn) && (e.sh || (e.asid == lk_asid));
   end

   always_comb begin
      rd_tag = '0;
      rd_pay = '0;
      if (int'(rd_idx) < ENTRIES) begin
         rd_tag = pack_tag(view[rd_idx]);
         rd_pay = pack_pay(view[rd_idx]);
      end
   end

   // Lowest index wins: scan downward so the last assignment is the lowest
   always_comb begin
      lk_ppn  = '0;
      lk_attr = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) begin
            lk_ppn  = view[i].ppn;
            lk_attr = attr_of(view[i]);
         end
      end
   end

   assign lk_hit   = |match;
   assign lk_multi = ($countones(match) > 1);

endmodule

// File: rtl/utlb_mmio.sv
module utlb_mmio
   import utlb_pkg::*;
#(
   parameter  int ENTRIES = 64,
   parameter  int ENT_LSB = 8,
   parameter  int SEL_BIT = 24,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mm_req,
   input  logic             mm_we,
   input  logic [1:0]       mm_size,
   input  logic             mm_priv,
   input  logic             mm_ifetch,
   input  logic [31:0]      mm_addr,
   input  logic [31:0]      rd_tag,
   input  logic [31:0]      rd_pay,
   output logic [IDX_W-1:0] idx,
   output logic             sel_pay,
   output logic             wr_en,
   output logic             mm_rvalid,
   output logic [31:0]      mm_rdata,
   output logic             mm_err
);

   logic acc;
   logic unused_addr;

   assign unused_addr = ^mm_addr;
   assign acc     = mm_req && (mm_size == SZ_WORD) && mm_priv && !mm_ifetch
                    && (mm_addr[1:0] == 2'b00);
   assign idx     = mm_addr[ENT_LSB +: IDX_W];
   assign sel_pay = mm_addr[SEL_BIT];
   assign wr_en   = acc && mm_we;

   always_ff @(posedge clk) begin
      if (rst) begin
         mm_rvalid <= 1'b0;
         mm_err    <= 1'b0;
         mm_rdata  <= '0;
      end else begin
         mm_rvalid <= acc && !mm_we;
         mm_err    <= mm_req && !acc;
         if (acc && !mm_we) begin
            mm_rdata <= sel_pay ? rd_pay : rd_tag;
         end
      end
   end

endmodule

// File: rtl/utlb_top.sv
module utlb_top
   import utlb_pkg::*;
#(
   parameter  int ENTRIES = 64,
   parameter  int ENT_LSB = 8,
   parameter  int SEL_BIT = 24,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pth_we,
   input  logic [31:0]       pth_wdata,
   input  logic              ptl_we,
   input  logic [31:0]       ptl_wdata,
   input  logic              ctl_we,
   input  logic [IDX_W-1:0]  ctl_urc_wr,
   input  logic [IDX_W-1:0]  ctl_urb_wr,
   input  logic              load_cmd,
   output logic [IDX_W-1:0]  ctl_urc,
   output logic [IDX_W-1:0]  ctl_urb,
   input  logic              mm_req,
   input  logic              mm_we,
   input  logic [1:0]        mm_size,
   input  logic              mm_priv,
   input  logic              mm_ifetch,
   input  logic [31:0]       mm_addr,
   input  logic [31:0]       mm_wdata,
   output logic              mm_rvalid,
   output logic [31:0]       mm_rdata,
   output logic              mm_err,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic              lk_multi,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [7:0]        lk_attr
);

   // Elaboration-time parameter checks
   if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
      $error("utlb_top: ENTRIES must lie in 2..256");
   end
   if (ENT_LSB < 2 || ENT_LSB + IDX_W > SEL_BIT || SEL_BIT > 31) begin : g_bad_decode
      $error("utlb_top: index field and view select bit overlap or leave the word");
   end
   if (A_VPN_LSB + VPN_W != 32 || D_PPN_LSB + PPN_W > 32 || ASID_W > A_V_BIT) begin : g_bad_layout
      $error("utlb_top: field layout does not fit a 32-bit word");
   end

   tlb_ent_t         stage_q;
   tlb_ent_t         stage_d;
   logic [IDX_W-1:0] mm_idx;
   logic             mm_sel_pay;
   logic             mm_wr;
   logic [31:0]      rd_tag;
   logic [31:0]      rd_pay;
   tlb_attr_t        attr_s;
   logic             unused_hi;

   assign unused_hi = ^pth_wdata;

   // Staging registers: high word fills VPN/ASID, low word the rest
   always_comb begin
      stage_d = stage_q;
      if (pth_we) begin
         stage_d.vpn  = pth_wdata[A_VPN_LSB +: VPN_W];
         stage_d.asid = pth_wdata[ASID_W-1:0];
      end
      if (ptl_we) begin
         stage_d = merge_pay(stage_d, ptl_wdata);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) stage_q <= '0;
      else     stage_q <= stage_d;
   end

   utlb_repl #(.ENTRIES(ENTRIES)) u_repl (
      .clk    (clk),
      .rst    (rst),
      .ctl_we (ctl_we),
      .urc_wr (ctl_urc_wr),
      .urb_wr (ctl_urb_wr),
      .load   (load_cmd),
      .urc    (ctl_urc),
      .urb    (ctl_urb)
   );

   utlb_mmio #(.ENTRIES(ENTRIES), .ENT_LSB(ENT_LSB), .SEL_BIT(SEL_BIT)) u_mmio (
      .clk       (clk),
      .rst       (rst),
      .mm_req    (mm_req),
      .mm_we     (mm_we),
      .mm_size   (mm_size),
      .mm_priv   (mm_priv),
      .mm_ifetch (mm_ifetch),
      .mm_addr   (mm_addr),
      .rd_tag    (rd_tag),
      .rd_pay    (rd_pay),
      .idx       (mm_idx),
      .sel_pay   (mm_sel_pay),
      .wr_en     (mm_wr),
      .mm_rvalid (mm_rvalid),
      .mm_rdata  (mm_rdata),
      .mm_err    (mm_err)
   );

   utlb_store #(.ENTRIES(ENTRIES)) u_store (
      .clk      (clk),
      .rst      (rst),
      .ld_en    (load_cmd),
      .ld_idx   (ctl_urc),
      .ld_ent   (stage_q),
      .mw_en    (mm_wr),
      .mw_pay   (mm_sel_pay),
      .mw_idx   (mm_idx),
      .mw_word  (mm_wdata),
      .rd_idx   (mm_idx),
      .rd_tag   (rd_tag),
      .rd_pay   (rd_pay),
      .lk_vpn   (lk_vpn),
      .lk_asid  (lk_asid),
      .lk_hit   (lk_hit),
      .lk_multi (lk_multi),
      .lk_ppn   (lk_ppn),
      .lk_attr  (attr_s)
   );

   assign lk_attr = attr_s;

endmodule

// File: rtl/utlb_chk.sv
module utlb_chk #(
   parameter  int ENTRIES = 64,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input logic             clk,
   input logic             rst,
   input logic             ctl_we,
   input logic [IDX_W-1:0] ctl_urc_wr,
   input logic [IDX_W-1:0] ctl_urb_wr,
   input logic             load_cmd,
   input logic [IDX_W-1:0] ctl_urc,
   input logic [IDX_W-1:0] ctl_urb,
   input logic             mm_req,
   input logic             mm_we,
   input logic [1:0]       mm_size,
   input logic             mm_priv,
   input logic             mm_ifetch,
   input logic [1:0]       mm_alo,
   input logic             mm_rvalid,
   input logic             mm_err,
   input logic             lk_hit,
   input logic             lk_multi
);

   logic acc_ok;
   assign acc_ok = (mm_size == 2'b10) && mm_priv && !mm_ifetch && (mm_alo == 2'b00);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (ctl_urc == '0 && ctl_urb == '0));

   // R4
   ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
      ctl_we |=> (ctl_urc == $past(ctl_urc_wr) && ctl_urb == $past(ctl_urb_wr)));

   // R3
   boundary_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (load_cmd && !ctl_we && ctl_urb != '0 && IDX_W'(ctl_urc + 1'b1) == ctl_urb)
      |=> (ctl_urc == '0));

   // R3
   counter_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!load_cmd && !ctl_we) |=> ($stable(ctl_urc) && $stable(ctl_urb)));

   // R10
   reject_access_chk: assert property (@(posedge clk) disable iff (rst)
      (mm_req && !acc_ok) |=> (mm_err && !mm_rvalid));

   // R11
   read_return_chk: assert property (@(posedge clk) disable iff (rst)
      (mm_req && acc_ok && !mm_we) |=> (mm_rvalid && !mm_err));

   // R10
   port_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !mm_req |=> (!mm_rvalid && !mm_err));

   // R6
   multi_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
      lk_multi |-> lk_hit);

endmodule

bind utlb_top utlb_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ctl_we     (ctl_we),
   .ctl_urc_wr (ctl_urc_wr),
   .ctl_urb_wr (ctl_urb_wr),
   .load_cmd   (load_cmd),
   .ctl_urc    (ctl_urc),
   .ctl_urb    (ctl_urb),
   .mm_req     (mm_req),
   .mm_we      (mm_we),
   .mm_size    (mm_size),
   .mm_priv    (mm_priv),
   .mm_ifetch  (mm_ifetch),
   .mm_alo     (mm_addr[1:0]),
   .mm_rvalid  (mm_rvalid),
   .mm_err     (mm_err),
   .lk_hit     (lk_hit),
   .lk_multi   (lk_multi)
);

// File: tb/utlb_top_tb_top.sv
`timescale 1ns/1ps
module utlb_top_tb_top;

   localparam int N = 64;

   logic        clk = 1'b0;
   logic        rst;
   logic        pth_we, ptl_we, ctl_we, load_cmd;
   logic [31:0] pth_wdata, ptl_wdata;
   logic [5:0]  ctl_urc_wr, ctl_urb_wr, ctl_urc, ctl_urb;
   logic        mm_req, mm_we, mm_priv, mm_ifetch;
   logic [1:0]  mm_size;
   logic [31:0] mm_addr, mm_wdata, mm_rdata;
   logic        mm_rvalid, mm_err;
   logic [21:0] lk_vpn;
   logic [7:0]  lk_asid;
   logic        lk_hit, lk_multi;
   logic [18:0] lk_ppn;
   logic [7:0]  lk_attr;

   always #10 clk = ~clk;

   utlb_top dut_i (
      .clk(clk), .rst(rst),
      .pth_we(pth_we), .pth_wdata(pth_wdata), .ptl_we(ptl_we), .ptl_wdata(ptl_wdata),
      .ctl_we(ctl_we), .ctl_urc_wr(ctl_urc_wr), .ctl_urb_wr(ctl_urb_wr),
      .load_cmd(load_cmd), .ctl_urc(ctl_urc), .ctl_urb(ctl_urb),
      .mm_req(mm_req), .mm_we(mm_we), .mm_size(mm_size), .mm_priv(mm_priv),
      .mm_ifetch(mm_ifetch), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
      .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata), .mm_err(mm_err),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_multi(lk_multi),
      .lk_ppn(lk_ppn), .lk_attr(lk_attr)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Reference model of the entries
   logic [21:0] m_vpn  [N];
   logic [7:0]  m_asid [N];
   logic [18:0] m_ppn  [N];
   logic [1:0]  m_sz   [N];
   logic [1:0]  m_pr   [N];
   logic        m_c [N], m_d [N], m_wt [N], m_sh [N], m_v [N];
   logic [5:0]  m_urc, m_urb;
   logic [31:0] s_hi, s_lo;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_tag(int i);
      logic [31:0] w;
      w = '0;
      w[31:10] = m_vpn[i]; w[9] = m_d[i]; w[8] = m_v[i]; w[7:0] = m_asid[i];
      return w;
   endfunction

   function automatic logic [31:0] exp_pay(int i);
      logic [31:0] w;
      w = '0;
      w[28:10] = m_ppn[i]; w[9] = m_v[i]; w[8] = m_d[i]; w[7:6] = m_sz[i];
      w[5:4] = m_pr[i]; w[3] = m_c[i]; w[2] = m_wt[i]; w[1] = m_sh[i];
      return w;
   endfunction

   function automatic void put_pay(int i, logic [31:0] w);
      m_ppn[i] = w[28:10]; m_v[i] = w[9]; m_d[i] = w[8]; m_sz[i] = w[7:6];
      m_pr[i] = w[5:4]; m_c[i] = w[3]; m_wt[i] = w[2]; m_sh[i] = w[1];
   endfunction

   function automatic void put_tag(int i, logic [31:0] w);
      m_vpn[i] = w[31:10]; m_d[i] = w[9]; m_v[i] = w[8]; m_asid[i] = w[7:0];
   endfunction

   function automatic logic [5:0] next_urc(logic [5:0] c, logic [5:0] b);
      logic [5:0] n;
      n = c + 6'd1;
      if (b != 6'd0 && n == b) n = 6'd0;
      return n;
   endfunction

   function automatic logic [31:0] mk_hi(logic [21:0] vpn, logic [7:0] asid);
      return {vpn, 2'b00, asid};
   endfunction

   function automatic logic [31:0] mk_lo(logic [18:0] ppn, logic v, logic d, logic [1:0] sz,
                                         logic [1:0] pr, logic c, logic wt, logic sh);
      return {3'b000, ppn, v, d, sz, pr, c, wt, sh, 1'b0};
   endfunction

   function automatic void model_clear();
      for (int i = 0; i < N; i++) begin
         m_vpn[i] = '0; m_asid[i] = '0; put_pay(i, 32'h0);
      end
      m_urc = '0; m_urb = '0; s_hi = '0; s_lo = '0;
   endfunction

   task automatic wr_hi(input logic [31:0] w);
      pth_we = 1'b1; pth_wdata = w;
      @(negedge clk);
      pth_we = 1'b0; s_hi = w;
   endtask

   task automatic wr_lo(input logic [31:0] w);
      ptl_we = 1'b1; ptl_wdata = w;
      @(negedge clk);
      ptl_we = 1'b0; s_lo = w;
   endtask

   task automatic wr_ctl(input logic [5:0] c, input logic [5:0] b);
      ctl_we = 1'b1; ctl_urc_wr = c; ctl_urb_wr = b;
      @(negedge clk);
      ctl_we = 1'b0; m_urc = c; m_urb = b;
   endtask

   task automatic do_load(input string tag);
      int i;
      i = int'(m_urc);
      load_cmd = 1'b1;
      @(negedge clk);
      load_cmd = 1'b0;
      m_vpn[i] = s_hi[31:10]; m_asid[i] = s_hi[7:0]; put_pay(i, s_lo);
      m_urc = next_urc(m_urc, m_urb);
      chk({tag, " urc after load"}, 64'(ctl_urc), 64'(m_urc));
   endtask

   task automatic mm_acc(input bit we, input bit sel, input int idx, input logic [31:0] w,
                         input logic [1:0] sz, input bit pv, input bit fe,
                         input logic [1:0] lo2, input string tag);
      logic [31:0] a, exp;
      bit ok;
      a = '0; a[24] = sel; a[13:8] = 6'(idx); a[1:0] = lo2;
      ok  = (sz == 2'b10) && pv && !fe && (lo2 == 2'b00);
      exp = sel ? exp_pay(idx) : exp_tag(idx);
      mm_req = 1'b1; mm_we = we; mm_addr = a; mm_wdata = w;
      mm_size = sz; mm_priv = pv; mm_ifetch = fe;
      @(negedge clk);
      mm_req = 1'b0; mm_we = 1'b0;
      chk({tag, " R10 err"}, 64'(mm_err), 64'(!ok));
      chk({tag, " R11 rvalid"}, 64'(mm_rvalid), 64'(ok && !we));
      if (ok && !we) chk({tag, " R11 rdata"}, 64'(mm_rdata), 64'(exp));
      if (ok && we) begin
         if (sel) put_pay(idx, w);
         else     put_tag(idx, w);
      end
   endtask

   task automatic rd(input bit sel, input int idx, input string tag);
      mm_acc(1'b0, sel, idx, 32'h0, 2'b10, 1'b1, 1'b0, 2'b00, tag);
   endtask

   task automatic wr(input bit sel, input int idx, input logic [31:0] w, input string tag);
      mm_acc(1'b1, sel, idx, w, 2'b10, 1'b1, 1'b0, 2'b00, tag);
   endtask

   task automatic look(input logic [21:0] vpn, input logic [7:0] asid, input string tag);
      int first, cnt;
      logic [7:0] ea;
      lk_vpn = vpn; lk_asid = asid;
      #1;
      first = -1; cnt = 0;
      for (int i = 0; i < N; i++) begin
         if (m_v[i] && m_vpn[i] == vpn && (m_sh[i] || m_asid[i] == asid)) begin
            if (first < 0) first = i;
            cnt++;
         end
      end
      chk({tag, " R5 hit"}, 64'(lk_hit), 64'(cnt > 0));
      chk({tag, " R6 multi"}, 64'(lk_multi), 64'(cnt > 1));
      if (first >= 0) begin
         ea = {m_sz[first], m_pr[first], m_c[first], m_d[first], m_wt[first], m_sh[first]};
         chk({tag, " R5 ppn"}, 64'(lk_ppn), 64'(m_ppn[first]));
         chk({tag, " R5 attr"}, 64'(lk_attr), 64'(ea));
      end else begin
         chk({tag, " R5 miss ppn"}, 64'(lk_ppn), 64'h0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd4711);
      rst = 1'b1; pth_we = 0; ptl_we = 0; ctl_we = 0; load_cmd = 0;
      pth_wdata = '0; ptl_wdata = '0; ctl_urc_wr = '0; ctl_urb_wr = '0;
      mm_req = 0; mm_we = 0; mm_size = 2'b10; mm_priv = 1; mm_ifetch = 0;
      mm_addr = '0; mm_wdata = '0; lk_vpn = '0; lk_asid = '0;
      model_clear();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      chk("R1 urc", 64'(ctl_urc), 64'h0);
      chk("R1 urb", 64'(ctl_urb), 64'h0);
      rd(1'b0, 0, "R1 tag e0");
      rd(1'b1, 63, "R1 pay e63");
      look(22'h0, 8'h0, "R1 empty");

      // R2, R7, R8: directed load into entry 0
      wr_hi(mk_hi(22'h012345, 8'h3C) | 32'h300);
      wr_lo(mk_lo(19'h5A5A5, 1'b1, 1'b0, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0) | 32'hE000_0001);
      do_load("R2 e0");
      look(22'h012345, 8'h3C, "R2 e0");
      rd(1'b0, 0, "R7 tag e0");
      rd(1'b1, 0, "R8 pay e0");

      // R6, R5: two equal entries, lowest index wins; ASID and shared flag
      wr_hi(mk_hi(22'h000777, 8'h05));
      wr_lo(mk_lo(19'h00111, 1'b1, 1'b1, 2'b10, 2'b01, 1'b0, 1'b1, 1'b0));
      do_load("R2 e1");
      wr_lo(mk_lo(19'h00222, 1'b1, 1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0));
      do_load("R2 e2");
      look(22'h000777, 8'h05, "R6 dual");
      look(22'h000777, 8'h06, "R5 asid miss");
      wr_hi(mk_hi(22'h000888, 8'h09));
      wr_lo(mk_lo(19'h00333, 1'b1, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1));
      do_load("R2 e3");
      look(22'h000888, 8'h02, "R5 shared");

      // R9: V and D shared between views
      wr(1'b0, 5, mk_hi(22'h000ABC, 8'h11) | 32'h300, "R9 tag wr");
      rd(1'b1, 5, "R9 pay sees V D");
      look(22'h000ABC, 8'h11, "R9 hit");
      wr(1'b1, 5, mk_lo(19'h7FFFF, 1'b0, 1'b0, 2'b01, 2'b01, 1'b1, 1'b1, 1'b0), "R9 pay wr");
      rd(1'b0, 5, "R9 tag sees V D");
      look(22'h000ABC, 8'h11, "R9 miss");

      // R10: rejected accesses write nothing
      mm_acc(1'b1, 1'b0, 0, 32'hFFFF_FFFF, 2'b00, 1'b1, 1'b0, 2'b00, "R10 byte");
      mm_acc(1'b1, 1'b1, 0, 32'hFFFF_FFFF, 2'b01, 1'b1, 1'b0, 2'b00, "R10 half");
      mm_acc(1'b1, 1'b1, 0, 32'h0, 2'b10, 1'b0, 1'b0, 2'b00, "R10 user");
      mm_acc(1'b0, 1'b0, 0, 32'h0, 2'b10, 1'b1, 1'b1, 2'b00, "R10 fetch");
      mm_acc(1'b1, 1'b0, 0, 32'h0, 2'b10, 1'b1, 1'b0, 2'b10, "R10 misaligned");
      rd(1'b0, 0, "R10 tag intact");
      rd(1'b1, 0, "R10 pay intact");

      // R3: boundary wrap, zero boundary, counter above boundary
      wr_ctl(6'd0, 6'd3);
      do_load("R3 b3 a"); do_load("R3 b3 b"); do_load("R3 b3 wrap");
      chk("R3 wrap to zero", 64'(ctl_urc), 64'h0);
      wr_ctl(6'd62, 6'd0);
      do_load("R3 top-1"); do_load("R3 top wrap");
      chk("R3 top wraps", 64'(ctl_urc), 64'h0);
      wr_ctl(6'd10, 6'd4);
      do_load("R3 above boundary");
      chk("R3 above boundary", 64'(ctl_urc), 64'd11);

      // R4: control write and load in the same cycle
      wr_hi(mk_hi(22'h0CAFE, 8'h44));
      wr_lo(mk_lo(19'h12345, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0));
      ctl_we = 1'b1; ctl_urc_wr = 6'd20; ctl_urb_wr = 6'd0; load_cmd = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0; load_cmd = 1'b0;
      m_vpn[11] = s_hi[31:10]; m_asid[11] = s_hi[7:0]; put_pay(11, s_lo);
      m_urc = 6'd20; m_urb = 6'd0;
      chk("R4 urc wins", 64'(ctl_urc), 64'd20);
      chk("R4 urb", 64'(ctl_urb), 64'd0);
      rd(1'b0, 11, "R4 old index filled");

      // Random traffic
      for (int it = 0; it < 600; it++) begin
         int op;
         op = $urandom_range(0, 5);
         case (op)
            0: begin
               wr_hi(mk_hi(22'($urandom_range(0, 7)), 8'($urandom_range(0, 3))));
               wr_lo($urandom);
               do_load("R2 rnd");
            end
            1: wr_ctl(6'($urandom_range(0, 63)), 6'($urandom_range(0, 63)));
            2: begin
               logic [31:0] w;
               bit s;
               w = $urandom; s = 1'($urandom_range(0, 1));
               if (!s) w[31:10] = 22'($urandom_range(0, 7));
               if (!s) w[7:0] = 8'($urandom_range(0, 3));
               wr(s, $urandom_range(0, 63), w, "R9 rnd wr");
            end
            3: rd(1'($urandom_range(0, 1)), $urandom_range(0, 63), "R7 R8 rnd rd");
            4: look(22'($urandom_range(0, 7)), 8'($urandom_range(0, 3)), "R5 R6 rnd");
            default: mm_acc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                            $urandom_range(0, 63), $urandom, 2'($urandom_range(0, 1)),
                            1'($urandom_range(0, 1)), 1'b0, 2'b00, "R10 rnd");
         endcase
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule